// File: doc/BRIEF.md
# Password-Gated Two-Wire Memory Target

This block is the device end of a two-wire serial memory link: one clock line and one bidirectional data line. Every read or write must first name one of several stored passwords and present all of its bytes. The host then sends an address byte. The acknowledge in that byte's slot is the poll result, and it tells the host whether the password was accepted. Only after that acknowledge does data move between the bus and a small internal byte array. Any refusal, and the end of every transaction, returns the target to standby, where it ignores the clock.

Writes collect a full page in staging registers and commit it in a single step. A busy timer, counted in system clocks, stands in for the nonvolatile write time. While the timer runs, new commands are refused. A separate response input makes the target shift out a fixed 32-bit word, provided it is idle and not busy.

Both bus lines are sampled by a two-flop synchronizer on the system clock. The data output is split into a value and an enable, so the pad can sit outside the block.

Top module: `pwgate_mem`

## Requirements
- R1: After reset, sda_oe is 0, the target is in standby, and every array byte reads as 0x00.
- R2: A start condition (data falling while the clock is high) begins a new command from any state. A stop condition (data rising while the clock is high) returns to standby and releases the line. Data is sampled on clock rising edges and driven after falling edges.
- R3: The command byte carries the tag 10100 in bits [7:3], the operation in bit 2 (1 = read, 0 = write) and the password slot in bits [1:0]. A byte without the tag is not acknowledged, and the target goes to standby.
- R4: For WRITE_CYCLES system clocks after a page commit, a command byte is not acknowledged.
- R5: The command is followed by PW_BYTES password bytes, each acknowledged. With default parameters every slot's password is all zero bytes.
- R6: The byte after the password is the start address and the poll. It is acknowledged only if every password byte matched the chosen slot. Otherwise it is not acknowledged, and later bytes are ignored until the next start.
- R7: A write takes PAGE data bytes, each acknowledged. On the last one, all of them are stored at address+i modulo DEPTH, and the busy time begins.
- R8: A stop before the last page byte discards the staged bytes. The array is unchanged and no busy time starts.
- R9: A read sends array bytes MSB first, from the start address upward, wrapping modulo DEPTH. A host acknowledge continues the read; a host non-acknowledge ends it and returns to standby.
- R10: A rising edge on rsp_i in standby with no busy time makes the target drive RSP_WORD MSB first. Bit 31 appears at once, each clock falling edge advances one bit, and the line is released after the 32nd falling edge.
- R11: A rising edge on rsp_i during busy time is ignored, and the line stays released.
- R12: sda_oe is 1 only in a target acknowledge slot, a read data bit or a response bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line as seen at the pad |
| rsp_i | input | 1 | Request for the fixed response word |
| sda_o | output | 1 | Value driven on the data line when enabled |
| sda_oe | output | 1 | Data line drive enable (0 = high impedance) |

## Verification
The bench focuses on the boundaries of the gate.

- **Wrong last password byte.** A target that decides on the first bytes only, or compares one byte too few, would acknowledge the poll.
- **Stop after part of a page.** A design that writes bytes straight into the array, or starts the busy timer early, shows stale data or refuses the next command.
- **Command during the busy window.** A busy timer that is ignored or never loaded acknowledges that command.
- **Response request during busy time.** A response that escapes the busy check would drive data on an idle line.
- **Page crossing the top of the array.** This catches an address that fails to wrap modulo DEPTH.

// File: rtl/pwgate_pkg.sv
package pwgate_pkg;
   typedef enum logic [2:0] {
      PH_IDLE, PH_CMD, PH_PW, PH_POLL, PH_WR, PH_RD, PH_RSP
   } phase_t;

   localparam logic [4:0] CMD_TAG = 5'b10100;
endpackage

// File: rtl/pwgate_sync.sv
module pwgate_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_c,
   output logic stop_c
);
   logic [STAGES-1:0] scl_ff, sda_ff;
   logic              scl_q, sda_q, scl_s;

   initial assert (STAGES >= 2) else $error("pwgate_sync: STAGES must be at least 2");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_q  <= scl_ff[STAGES-1];
         sda_q  <= sda_ff[STAGES-1];
      end
   end

   assign scl_s    = scl_ff[STAGES-1];
   assign sda_s    = sda_ff[STAGES-1];
   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;
   assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/pwgate_keys.sv
module pwgate_keys #(
   parameter int NUM_PW   = 4,
   parameter int PW_BYTES = 8,
   parameter logic [NUM_PW*PW_BYTES*8-1:0] PW_INIT = '0,
   localparam int IW = (NUM_PW > 1) ? $clog2(NUM_PW) : 1,
   localparam int BW = (PW_BYTES > 1) ? $clog2(PW_BYTES) : 1
) (
   input  logic [IW-1:0] slot,
   input  logic [BW-1:0] sel,
   input  logic [7:0]    rx_byte,
   output logic          eq
);
   logic [7:0] key_byte;

   initial assert (NUM_PW >= 1 && PW_BYTES >= 1) else $error("pwgate_keys: bad sizes");

   generate
      if (NUM_PW == 1) begin : g_single
         logic unused_slot;
         assign unused_slot = ^slot;
         assign key_byte = PW_INIT[sel*8 +: 8];
      end else begin : g_multi
         assign key_byte = PW_INIT[(slot*PW_BYTES + sel)*8 +: 8];
      end
   endgenerate

   assign eq = (rx_byte == key_byte);
endmodule

// File: rtl/pwgate_array.sv
module pwgate_array #(
   parameter int DEPTH = 16,
   parameter int PAGE  = 4,
   localparam int AW  = $clog2(DEPTH),
   localparam int PGW = $clog2(PAGE)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           st_we,
   input  logic [PGW-1:0] st_idx,
   input  logic [7:0]     st_data,
   input  logic           commit,
   input  logic [AW-1:0]  base,
   input  logic [AW-1:0]  rd_addr,
   output logic [7:0]     rd_data
);
   logic [7:0] mem   [DEPTH];
   logic [7:0] stage [PAGE];

   initial assert (DEPTH >= 2 && (1 << AW) == DEPTH) else $error("pwgate_array: DEPTH must be a power of two");
   initial assert (PAGE >= 2 && PAGE <= DEPTH && (1 << PGW) == PAGE) else $error("pwgate_array: bad PAGE");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < PAGE; i++) stage[i] <= 8'h00;
      end else if (st_we) begin
         stage[st_idx] <= st_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
      end else if (commit) begin
         for (int i = 0; i < PAGE; i++)
            mem[base + AW'(i)] <= (i == PAGE-1) ? st_data : stage[i];
      end
   end

   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/pwgate_mem.sv
module pwgate_mem #(
   parameter int DEPTH        = 16,
   parameter int PAGE         = 4,
   parameter int NUM_PW       = 4,
   parameter int PW_BYTES     = 8,
   parameter int WRITE_CYCLES = 300,
   parameter int SYNC_STAGES  = 2,
   parameter logic [31:0] RSP_WORD = 32'hA213_1091,
   parameter logic [NUM_PW*PW_BYTES*8-1:0] PW_INIT = '0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   input  logic rsp_i,
   output logic sda_o,
   output logic sda_oe
);
   import pwgate_pkg::*;

   localparam int AW  = $clog2(DEPTH);
   localparam int PGW = $clog2(PAGE);
   localparam int IW  = (NUM_PW > 1) ? $clog2(NUM_PW) : 1;
   localparam int BW  = (PW_BYTES > 1) ? $clog2(PW_BYTES) : 1;
   localparam int CW  = $clog2(WRITE_CYCLES + 1);

   initial assert (NUM_PW <= 4) else $error("pwgate_mem: slot field is two bits");
   initial assert (WRITE_CYCLES >= 1) else $error("pwgate_mem: WRITE_CYCLES must be positive");

   logic sda_s, scl_rise, scl_fall, start_c, stop_c;
   logic [1:0] rsp_ff;
   logic rsp_q, rsp_rise;

   phase_t         phase, nxt, nxt_v;
   logic [3:0]     bitc;
   logic [7:0]     sh, tx;
   logic           is_rd, mism, fail, hack, ack_v, pw_eq;
   logic [IW-1:0]  slot;
   logic [BW-1:0]  pwc;
   logic [AW-1:0]  addr;
   logic [PGW-1:0] wc;
   logic [CW-1:0]  busy_cnt;
   logic [31:0]    rsp_sh;
   logic [4:0]     rsp_cnt;
   logic [7:0]     rd_data;
   logic byte_done, slot_end, commit, st_we, rsp_go, not_busy;

   pwgate_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_c(start_c), .stop_c(stop_c));

   pwgate_keys #(.NUM_PW(NUM_PW), .PW_BYTES(PW_BYTES), .PW_INIT(PW_INIT)) u_keys (
      .slot(slot), .sel(pwc), .rx_byte(sh), .eq(pw_eq));

   pwgate_array #(.DEPTH(DEPTH), .PAGE(PAGE)) u_array (
      .clk(clk), .rst_n(rst_n), .st_we(st_we), .st_idx(wc), .st_data(sh),
      .commit(commit), .base(addr), .rd_addr(addr), .rd_data(rd_data));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_ff <= 2'b00;
         rsp_q  <= 1'b0;
      end else begin
         rsp_ff <= {rsp_ff[0], rsp_i};
         rsp_q  <= rsp_ff[1];
      end
   end
   assign rsp_rise = rsp_ff[1] & ~rsp_q;

   assign not_busy  = (busy_cnt == '0);
   assign byte_done = scl_fall && (bitc == 4'd8);
   assign slot_end  = scl_fall && (bitc == 4'd9);
   assign st_we     = byte_done && (phase == PH_WR);
   assign commit    = st_we && (wc == PGW'(PAGE-1));
   assign rsp_go    = rsp_rise && (phase == PH_IDLE) && not_busy;

   always_comb begin
      ack_v = 1'b0;
      nxt_v = PH_IDLE;
      unique case (phase)
         PH_CMD: begin
            ack_v = (sh[7:3] == CMD_TAG) && not_busy;
            nxt_v = PH_PW;
         end
         PH_PW: begin
            ack_v = 1'b1;
            nxt_v = (pwc == BW'(PW_BYTES-1)) ? PH_POLL : PH_PW;
         end
         PH_POLL: begin
            ack_v = !mism && not_busy;
            nxt_v = is_rd ? PH_RD : PH_WR;
         end
         PH_WR: begin
            ack_v = 1'b1;
            nxt_v = (wc == PGW'(PAGE-1)) ? PH_IDLE : PH_WR;
         end
         default: ;
      endcase
   end

   always_comb begin
      unique case (phase)
         PH_RSP:  sda_o = rsp_sh[31];
         PH_RD:   sda_o = tx[7];
         default: sda_o = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_cnt <= '0;
      end else if (commit) begin
         busy_cnt <= CW'(WRITE_CYCLES);
      end else if (!not_busy) begin
         busy_cnt <= busy_cnt - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;  nxt <= PH_IDLE;  bitc <= '0;
         sh <= '0;  tx <= '0;  is_rd <= 1'b0;  mism <= 1'b0;
         fail <= 1'b0;  hack <= 1'b0;  slot <= '0;  pwc <= '0;
         addr <= '0;  wc <= '0;  rsp_sh <= '0;  rsp_cnt <= '0;
         sda_oe <= 1'b0;
      end else if (start_c) begin
         phase <= PH_CMD;  bitc <= '0;  sda_oe <= 1'b0;
      end else if (stop_c) begin
         phase <= PH_IDLE;  sda_oe <= 1'b0;
      end else if (rsp_go) begin
         phase <= PH_RSP;  rsp_sh <= RSP_WORD;  rsp_cnt <= '0;  sda_oe <= 1'b1;
      end else begin
         unique case (phase)
            PH_RSP: if (scl_fall) begin
               if (rsp_cnt == 5'd31) begin
                  phase  <= PH_IDLE;
                  sda_oe <= 1'b0;
               end else begin
                  rsp_sh  <= {rsp_sh[30:0], 1'b0};
                  rsp_cnt <= rsp_cnt + 1'b1;
               end
            end
            PH_RD: begin
               if (scl_rise && bitc <= 4'd8) begin
                  if (bitc == 4'd8) hack <= !sda_s;
                  bitc <= bitc + 1'b1;
               end
               if (scl_fall) begin
                  if (bitc >= 4'd1 && bitc <= 4'd7) begin
                     tx <= {tx[6:0], 1'b0};
                  end else if (bitc == 4'd8) begin
                     sda_oe <= 1'b0;
                  end else if (bitc == 4'd9) begin
                     bitc <= '0;
                     if (hack) begin
                        tx <= rd_data;  addr <= addr + 1'b1;  sda_oe <= 1'b1;
                     end else begin
                        phase <= PH_IDLE;
                     end
                  end
               end
            end
            PH_CMD, PH_PW, PH_POLL, PH_WR: begin
               if (scl_rise && bitc < 4'd8) begin
                  sh   <= {sh[6:0], sda_s};
                  bitc <= bitc + 1'b1;
               end else if (scl_rise && bitc == 4'd8) begin
                  bitc <= 4'd9;
               end
               if (byte_done) begin
                  sda_oe <= ack_v;
                  fail   <= !ack_v;
                  nxt    <= nxt_v;
                  unique case (phase)
                     PH_CMD: begin
                        is_rd <= sh[2];  slot <= IW'(sh[1:0]);
                        pwc <= '0;  mism <= 1'b0;
                     end
                     PH_PW: begin
                        mism <= mism | !pw_eq;
                        pwc  <= pwc + 1'b1;
                     end
                     PH_POLL: begin
                        addr <= sh[AW-1:0];  wc <= '0;
                     end
                     default: wc <= wc + 1'b1;
                  endcase
               end
               if (slot_end) begin
                  bitc   <= '0;
                  sda_oe <= 1'b0;
                  if (fail) begin
                     phase <= PH_IDLE;
                  end else begin
                     phase <= nxt;
                     if (nxt == PH_RD) begin
                        tx <= rd_data;  addr <= addr + 1'b1;  sda_oe <= 1'b1;
                     end
                  end
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/pwgate_chk.sv
module pwgate_chk #(
   parameter int CW = 9
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start_c,
   input logic                stop_c,
   input logic                sda_oe,
   input logic                commit,
   input logic [CW-1:0]       busy_cnt,
   input pwgate_pkg::phase_t  phase
);
   import pwgate_pkg::*;

   a_r2_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
      stop_c |=> !sda_oe);

   a_r2_start_release: assert property (@(posedge clk) disable iff (!rst_n)
      start_c |=> !sda_oe);

   a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE) |-> !sda_oe);

   a_r4_busy_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_cnt != '0 && !commit) |=> (busy_cnt == $past(busy_cnt) - 1'b1));

   a_r4_commit_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (busy_cnt == '0));

   a_r7_commit_loads_busy: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (busy_cnt != '0));
endmodule

bind pwgate_mem pwgate_chk #(.CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_c(start_c), .stop_c(stop_c),
   .sda_oe(sda_oe), .commit(commit), .busy_cnt(busy_cnt), .phase(phase));

// File: tb/pwgate_mem_bench.sv
module pwgate_mem_bench;
   localparam int CLK_PERIOD = 10;
   localparam int H = 6;
   localparam logic [31:0] RSP = 32'hA213_1091;

   logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, hsda = 1'b1, rsp = 1'b0;
   logic sda_o, sda_oe;
   logic line;
   int checks = 0, errors = 0;
   bit done = 0;

   assign line = sda_oe ? sda_o : hsda;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwgate_mem u_pwgate_mem (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(line), .rsp_i(rsp),
      .sda_o(sda_o), .sda_oe(sda_oe));

   task automatic wc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_start();
      hsda = 1'b1; wc(H); scl = 1'b1; wc(H); hsda = 1'b0; wc(H); scl = 1'b0; wc(H);
   endtask

   task automatic bus_stop();
      scl = 1'b0; hsda = 1'b0; wc(H); scl = 1'b1; wc(H); hsda = 1'b1; wc(H);
   endtask

   task automatic put_byte(input logic [7:0] b, output bit acked);
      for (int i = 7; i >= 0; i--) begin
         hsda = b[i]; wc(H); scl = 1'b1; wc(H); scl = 1'b0;
      end
      hsda = 1'b1; wc(H); scl = 1'b1; wc(H/2);
      acked = !line;
      wc(H/2); scl = 1'b0;
   endtask

   task automatic get_byte(output logic [7:0] b, input bit ack);
      for (int i = 7; i >= 0; i--) begin
         wc(H); scl = 1'b1; wc(H/2); b[i] = line; wc(H/2); scl = 1'b0;
      end
      hsda = !ack; wc(H); scl = 1'b1; wc(H); scl = 1'b0; hsda = 1'b1;
   endtask

   task automatic open_txn(input logic [7:0] cmd, input logic [7:0] last_pw,
                           input logic [7:0] adr, output bit ack_cmd, output bit ack_poll);
      bit a, all_pw;
      bus_start();
      put_byte(cmd, ack_cmd);
      all_pw = 1;
      for (int i = 0; i < 8; i++) begin
         put_byte((i == 7) ? last_pw : 8'h00, a);
         all_pw &= a;
      end
      chk(all_pw, "R5 password bytes acked", 32'(all_pw), 32'd1);
      put_byte(adr, ack_poll);
   endtask

   task automatic write_page(input logic [7:0] cmd, input logic [7:0] adr, input logic [31:0] data, input string tag);
      bit ac, ap, a, all;
      open_txn(cmd, 8'h00, adr, ac, ap);
      chk(ac, {tag, " R3 write command acked"}, 32'(ac), 32'd1);
      chk(ap, {tag, " R6 poll acked on match"}, 32'(ap), 32'd1);
      all = 1;
      for (int i = 3; i >= 0; i--) begin
         put_byte(data[i*8 +: 8], a);
         all &= a;
      end
      chk(all, {tag, " R7 page bytes acked"}, 32'(all), 32'd1);
      bus_stop();
   endtask

   task automatic read_check(input logic [7:0] cmd, input logic [7:0] adr, input int n,
                             input logic [31:0] exp, input string tag);
      bit ac, ap;
      logic [7:0] b;
      open_txn(cmd, 8'h00, adr, ac, ap);
      chk(ac && ap, {tag, " R6 read gate open"}, 32'({ac, ap}), 32'd3);
      for (int i = n-1; i >= 0; i--) begin
         get_byte(b, i != 0);
         chk(b == exp[i*8 +: 8], {tag, " R9 read data"}, 32'(b), 32'(exp[i*8 +: 8]));
      end
      wc(H);
      chk(!sda_oe, {tag, " R12 released after host nack"}, 32'(sda_oe), 32'd0);
      bus_stop();
   endtask

   task automatic get_bits(input int n, output logic [31:0] v);
      v = '0;
      for (int i = 0; i < n; i++) begin
         wc(H); scl = 1'b1; wc(H/2); v = {v[30:0], line}; wc(H/2); scl = 1'b0;
      end
   endtask

   task automatic pulse_rsp();
      scl = 1'b0; wc(H);
      rsp = 1'b1; wc(4); rsp = 1'b0; wc(6);
   endtask

   task automatic t_reset();
      chk(!sda_oe, "R1 enable off after reset", 32'(sda_oe), 32'd0);
      read_check(8'hA4, 8'h00, 2, 32'h0000, "R1 array cleared");
   endtask

   task automatic t_write_and_busy();
      bit a;
      write_page(8'hA1, 8'h04, 32'h1122_3344, "page@4");
      bus_start();
      put_byte(8'hA6, a);
      chk(!a, "R4 command refused while busy", 32'(a), 32'd0);
      bus_stop();
      wc(400);
      read_check(8'hA6, 8'h04, 4, 32'h1122_3344, "R7 committed page");
   endtask

   task automatic t_bad_password();
      bit ac, ap, a;
      open_txn(8'hA4, 8'h5A, 8'h04, ac, ap);
      chk(ac, "R3 read command acked", 32'(ac), 32'd1);
      chk(!ap, "R6 poll refused on last byte mismatch", 32'(ap), 32'd0);
      put_byte(8'h00, a);
      chk(!a, "R6 standby after refusal", 32'(a), 32'd0);
      bus_stop();
   endtask

   task automatic t_bad_cmd();
      bit a;
      bus_start();
      put_byte(8'h31, a);
      chk(!a, "R3 untagged command refused", 32'(a), 32'd0);
      put_byte(8'h00, a);
      chk(!a, "R3 standby after bad command", 32'(a), 32'd0);
      bus_stop();
   endtask

   task automatic t_cancel();
      bit ac, ap, a;
      open_txn(8'hA0, 8'h00, 8'h08, ac, ap);
      put_byte(8'h77, a);
      put_byte(8'h88, a);
      bus_stop();
      bus_start();
      put_byte(8'hA4, a);
      chk(a, "R8 no busy time after cancelled write", 32'(a), 32'd1);
      bus_stop();
      read_check(8'hA7, 8'h08, 2, 32'h0000, "R8 array unchanged");
   endtask

   task automatic t_wrap();
      write_page(8'hA2, 8'h0E, 32'h0506_0708, "page@14");
      wc(400);
      read_check(8'hA5, 8'h0E, 4, 32'h0506_0708, "R9 wrap read");
      read_check(8'hA5, 8'h00, 2, 32'h0708, "R7 wrap store");
   endtask

   task automatic t_response();
      logic [31:0] v;
      pulse_rsp();
      get_bits(32, v);
      chk(v == RSP, "R10 response word", v, RSP);
      wc(H);
      chk(!sda_oe, "R10 released after 32 bits", 32'(sda_oe), 32'd0);
      scl = 1'b1; wc(H);
   endtask

   task automatic t_response_busy();
      logic [31:0] v;
      write_page(8'hA3, 8'h00, 32'hAABB_CCDD, "page@0");
      pulse_rsp();
      get_bits(8, v);
      chk(v[7:0] == 8'hFF, "R11 response ignored while busy", v, 32'hFF);
      scl = 1'b1; wc(400);
      t_response();
   endtask

   initial begin
      wc(5);
      rst_n = 1'b1;
      wc(5);
      t_reset();
      t_write_and_busy();
      t_bad_password();
      t_bad_cmd();
      t_cancel();
      t_wrap();
      t_response();
      t_response_busy();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule